// File: doc/BRIEF.md
# Multicycle Fetch-Decode-Execute Controller

This block is the control core of a very small accumulator machine. It walks every instruction through three one-clock phases. In the fetch phase the word at the program counter is latched into the current-instruction register and the counter is advanced by one. The decode phase turns the opcode and register fields into control signals. The execute phase performs the operation. After execute the controller returns to fetch, using whatever value the program counter now holds.

The block contains the program counter, the instruction register, four 8-bit general-purpose registers, an accumulator and a set of comparison flags. Instruction memory is read asynchronously at the program counter. Data memory sits outside the block behind a synchronous-read port. A load issues its read during decode and writes the returned byte into a register at the end of execute. Arithmetic results go to the accumulator, and a store writes the accumulator to memory. A compare sets the flags, and the conditional branch later tests those flags. A halt opcode parks the controller until the next reset.

Top module: `fde_ctrl`

## Requirements
- R1: Instructions are 16 bits wide, with the opcode in [15:12].
  - Opcode 1 loads register [11:10] from address [7:0].
  - Opcode 2 stores the accumulator to address [7:0].
  - Opcode 3 is an ALU operation with function [6:4] and sources [3:2] (A) and [1:0] (B).
  - Opcode 4 compares register [3:2] with register [1:0].
  - Opcode 5 jumps to [7:0].
  - Opcode 6 branches to [7:0] if greater or equal.
  - Opcode 15 halts.
- R2: The phase output steps fetch (0), decode (1), execute (2), then back to fetch, with each phase lasting exactly one clock.
- R3: Fetch latches the instruction at the program counter and increments the counter by one in the same clock. The counter does not change during decode.
- R4: A load drives a data read only in decode. The returned byte is written into the destination register at the end of execute.
- R5: A store drives a data write of the accumulator to the instruction's address, only during execute.
- R6: ALU function codes write their result, modulo 256, to the accumulator:
  - 0: A+B
  - 1: A-B
  - 2: A&B
  - 3: A|B
  - 4: A^B
  - 5: A+1
  - 6: A-1
  - 7: A shifted left by one
- R7: A compare sets the flags output to {gt, eq, lt} from an unsigned comparison of A with B. No other instruction changes the flags.
- R8: A jump loads its target into the program counter at the end of execute.
- R9: Branch-if-greater-or-equal loads its target when the gt or eq flag is set. Otherwise execution continues at the next sequential address.
- R10: After a halt, the halted output stays high, the phase output reads 3, and the program counter no longer changes.
- R11: While reset is held:
  - the program counter, accumulator and flags are zero;
  - the phase is fetch;
  - halted is low;
  - no data read or write is driven.
- R12: An unassigned opcode acts as a no-op. It leaves registers, accumulator, flags and memory unchanged, and execution moves on to the next address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | 8 | Instruction address (the program counter) |
| imem_rdata | input | 16 | Instruction word at imem_addr |
| dmem_addr | output | 8 | Data memory address |
| dmem_re | output | 1 | Data read request; data is returned on the next clock |
| dmem_we | output | 1 | Data write strobe |
| dmem_wdata | output | 8 | Data write value (accumulator) |
| dmem_rdata | input | 8 | Registered read data |
| acc_o | output | 8 | Accumulator |
| flags_o | output | 3 | Comparison flags {gt, eq, lt} |
| phase_o | output | 2 | Current phase: 0 fetch, 1 decode, 2 execute, 3 halted |
| halted_o | output | 1 | High once a halt has executed |

## Verification
The bound checker watches the following on every clock:
- the phase order;
- the counter step in fetch and the hold in decode;
- the counter value after a jump or taken branch;
- the fall-through of an untaken branch;
- the flags changing only on a compare;
- the phases in which data reads and writes may appear;
- the frozen halted state.

The bench scenarios cover what a single cycle cannot show:
- the value a load actually delivers into a register;
- each ALU function's result at memory;
- the full fetch-address trace of a four-pass counting loop;
- that an unassigned opcode leaves both memory and the accumulator untouched.

// File: rtl/fde_pkg.sv
package fde_pkg;

  localparam int INSTR_W = 16;
  localparam int ADDR_W  = 8;
  localparam int RSEL_W  = 2;

  typedef enum logic [3:0] {
    OP_NOP   = 4'h0,
    OP_LOAD  = 4'h1,
    OP_STORE = 4'h2,
    OP_ALU   = 4'h3,
    OP_CMP   = 4'h4,
    OP_JMP   = 4'h5,
    OP_BGE   = 4'h6,
    OP_HALT  = 4'hF
  } opcode_e;

  typedef enum logic [2:0] {
    FN_ADD = 3'd0,
    FN_SUB = 3'd1,
    FN_AND = 3'd2,
    FN_OR  = 3'd3,
    FN_XOR = 3'd4,
    FN_INC = 3'd5,
    FN_DEC = 3'd6,
    FN_SHL = 3'd7
  } alu_fn_e;

  typedef enum logic [1:0] {
    ST_FETCH  = 2'd0,
    ST_DECODE = 2'd1,
    ST_EXEC   = 2'd2,
    ST_HALT   = 2'd3
  } phase_e;

  typedef struct packed {
    logic              ld;
    logic              st;
    logic              alu;
    logic              cmp;
    logic              jmp;
    logic              bge;
    logic              halt;
    alu_fn_e           fn;
    logic [RSEL_W-1:0] ra;
    logic [RSEL_W-1:0] rb;
    logic [RSEL_W-1:0] rd;
    logic [ADDR_W-1:0] addr;
  } ctrl_t;

endpackage

// File: rtl/fde_decoder.sv
module fde_decoder
  import fde_pkg::*;
(
  input  logic [INSTR_W-1:0] cir,
  output ctrl_t              ctrl
);

  opcode_e op;
  logic    unused_bits;

  assign op          = opcode_e'(cir[15:12]);
  assign unused_bits = ^cir[9:8];

  always_comb begin
    ctrl      = '0;
    ctrl.fn   = alu_fn_e'(cir[6:4]);
    ctrl.ra   = cir[3:2];
    ctrl.rb   = cir[1:0];
    ctrl.rd   = cir[11:10];
    ctrl.addr = cir[7:0];
    case (op)
      OP_LOAD:  ctrl.ld   = 1'b1;
      OP_STORE: ctrl.st   = 1'b1;
      OP_ALU:   ctrl.alu  = 1'b1;
      OP_CMP:   ctrl.cmp  = 1'b1;
      OP_JMP:   ctrl.jmp  = 1'b1;
      OP_BGE:   ctrl.bge  = 1'b1;
      OP_HALT:  ctrl.halt = 1'b1;
      default:  ;
    endcase
  end

endmodule

// File: rtl/fde_regfile.sv
module fde_regfile #(
  parameter int DATA_W = 8,
  parameter int NREGS  = 4,
  localparam int SEL_W = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SEL_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [SEL_W-1:0]  raddr_a,
  input  logic [SEL_W-1:0]  raddr_b,
  output logic [DATA_W-1:0] rdata_a,
  output logic [DATA_W-1:0] rdata_b
);

  logic [DATA_W-1:0] regs [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        regs[g] <= '0;
      end else if (we && (waddr == SEL_W'(g))) begin
        regs[g] <= wdata;
      end
    end
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];

endmodule

// File: rtl/fde_alu.sv
module fde_alu
  import fde_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_fn_e           fn,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y,
  output logic              gt,
  output logic              eq,
  output logic              lt
);

  function automatic logic [DATA_W-1:0] alu_calc(
    input alu_fn_e           f,
    input logic [DATA_W-1:0] x,
    input logic [DATA_W-1:0] z
  );
    case (f)
      FN_ADD:  return x + z;
      FN_SUB:  return x - z;
      FN_AND:  return x & z;
      FN_OR:   return x | z;
      FN_XOR:  return x ^ z;
      FN_INC:  return x + DATA_W'(1);
      FN_DEC:  return x - DATA_W'(1);
      default: return {x[DATA_W-2:0], 1'b0};
    endcase
  endfunction

  function automatic logic [2:0] cmp_calc(
    input logic [DATA_W-1:0] x,
    input logic [DATA_W-1:0] z
  );
    return {x > z, x == z, x < z};
  endfunction

  assign y            = alu_calc(fn, a, b);
  assign {gt, eq, lt} = cmp_calc(a, b);

endmodule

// File: rtl/fde_ctrl.sv
module fde_ctrl
  import fde_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic [ADDR_W-1:0]   imem_addr,
  input  logic [INSTR_W-1:0]  imem_rdata,
  output logic [ADDR_W-1:0]   dmem_addr,
  output logic                dmem_re,
  output logic                dmem_we,
  output logic [DATA_W-1:0]   dmem_wdata,
  input  logic [DATA_W-1:0]   dmem_rdata,
  output logic [DATA_W-1:0]   acc_o,
  output logic [2:0]          flags_o,
  output logic [1:0]          phase_o,
  output logic                halted_o
);

  localparam int SEL_W = $clog2(NUM_REGS);

  phase_e             state_q;
  logic [ADDR_W-1:0]  pc_q;
  logic [INSTR_W-1:0] cir_q;
  logic [DATA_W-1:0]  acc_q;
  logic [2:0]         flags_q;

  ctrl_t              ctrl;
  logic [DATA_W-1:0]  opa;
  logic [DATA_W-1:0]  opb;
  logic [DATA_W-1:0]  alu_y;
  logic               c_gt;
  logic               c_eq;
  logic               c_lt;

  // Named events for the bound checker.
  logic               in_exec;
  logic               rf_we;
  logic               ev_cmp_exec;
  logic               ev_bge_exec;
  logic               ev_pc_load;
  logic [ADDR_W-1:0]  ev_target;

  fde_decoder u_dec (
    .cir  (cir_q),
    .ctrl (ctrl)
  );

  fde_regfile #(
    .DATA_W (DATA_W),
    .NREGS  (NUM_REGS)
  ) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (rf_we),
    .waddr   (SEL_W'(ctrl.rd)),
    .wdata   (dmem_rdata),
    .raddr_a (SEL_W'(ctrl.ra)),
    .raddr_b (SEL_W'(ctrl.rb)),
    .rdata_a (opa),
    .rdata_b (opb)
  );

  fde_alu #(
    .DATA_W (DATA_W)
  ) u_alu (
    .fn (ctrl.fn),
    .a  (opa),
    .b  (opb),
    .y  (alu_y),
    .gt (c_gt),
    .eq (c_eq),
    .lt (c_lt)
  );

  assign in_exec     = (state_q == ST_EXEC);
  assign rf_we       = in_exec & ctrl.ld;
  assign ev_cmp_exec = in_exec & ctrl.cmp;
  assign ev_bge_exec = in_exec & ctrl.bge;
  assign ev_pc_load  = in_exec & (ctrl.jmp | (ctrl.bge & (flags_q[2] | flags_q[1])));
  assign ev_target   = ctrl.addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_FETCH;
      pc_q    <= '0;
      cir_q   <= '0;
      acc_q   <= '0;
      flags_q <= '0;
    end else begin
      case (state_q)
        ST_FETCH: begin
          cir_q   <= imem_rdata;
          pc_q    <= pc_q + ADDR_W'(1);
          state_q <= ST_DECODE;
        end
        ST_DECODE: begin
          state_q <= ST_EXEC;
        end
        ST_EXEC: begin
          if (ctrl.alu)  acc_q   <= alu_y;
          if (ctrl.cmp)  flags_q <= {c_gt, c_eq, c_lt};
          if (ev_pc_load) pc_q   <= ev_target;
          state_q <= ctrl.halt ? ST_HALT : ST_FETCH;
        end
        default: begin
          state_q <= ST_HALT;
        end
      endcase
    end
  end

  assign imem_addr  = pc_q;
  assign dmem_addr  = ctrl.addr;
  assign dmem_re    = (state_q == ST_DECODE) & ctrl.ld;
  assign dmem_we    = in_exec & ctrl.st;
  assign dmem_wdata = acc_q;
  assign acc_o      = acc_q;
  assign flags_o    = flags_q;
  assign phase_o    = state_q;
  assign halted_o   = (state_q == ST_HALT);

endmodule

// File: rtl/fde_ctrl_chk.sv
module fde_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] phase,
  input logic [7:0] pc,
  input logic       halted,
  input logic       dmem_re,
  input logic       dmem_we,
  input logic       ev_pc_load,
  input logic [7:0] ev_target,
  input logic       ev_bge,
  input logic       ev_cmp,
  input logic [2:0] flags
);

  AST_PHASE_F_TO_D: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 2'd0 |=> phase == 2'd1); // R2
  AST_PHASE_D_TO_E: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 2'd1 |=> phase == 2'd2); // R2
  AST_PHASE_E_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 2'd2 |=> (phase == 2'd0 || phase == 2'd3)); // R2
  AST_FETCH_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 2'd0 |=> pc == 8'($past(pc) + 8'd1)); // R3
  AST_DECODE_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 2'd1 |=> $stable(pc)); // R3
  AST_READ_IN_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_re |-> phase == 2'd1); // R4
  AST_WRITE_IN_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |-> phase == 2'd2); // R5
  AST_FLAGS_ONLY_CMP: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_cmp |=> $stable(flags)); // R7
  AST_PC_LOAD_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pc_load |=> pc == $past(ev_target)); // R8
  AST_BGE_TAKEN_COND: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_bge && ev_pc_load) |-> (flags[2] || flags[1])); // R9
  AST_BGE_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_bge && !flags[2] && !flags[1]) |=> $stable(pc)); // R9
  AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(pc) && phase == 2'd3)); // R10

endmodule

bind fde_ctrl fde_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .phase      (phase_o),
  .pc         (imem_addr),
  .halted     (halted_o),
  .dmem_re    (dmem_re),
  .dmem_we    (dmem_we),
  .ev_pc_load (ev_pc_load),
  .ev_target  (ev_target),
  .ev_bge     (ev_bge_exec),
  .ev_cmp     (ev_cmp_exec),
  .flags      (flags_o)
);

// File: tb/sim_fde_ctrl.sv
`timescale 1ns/1ps
module sim_fde_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  imem_addr;
  logic [15:0] imem_rdata;
  logic [7:0]  dmem_addr;
  logic        dmem_re;
  logic        dmem_we;
  logic [7:0]  dmem_wdata;
  logic [7:0]  dmem_rdata;
  logic [7:0]  acc_o;
  logic [2:0]  flags_o;
  logic [1:0]  phase_o;
  logic        halted_o;

  int compared = 0;
  int mismatched = 0;

  always #4 clk = ~clk;

  fde_ctrl u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_addr  (dmem_addr),
    .dmem_re    (dmem_re),
    .dmem_we    (dmem_we),
    .dmem_wdata (dmem_wdata),
    .dmem_rdata (dmem_rdata),
    .acc_o      (acc_o),
    .flags_o    (flags_o),
    .phase_o    (phase_o),
    .halted_o   (halted_o)
  );

  logic [15:0] prog [256];
  logic [7:0]  dmem [256];
  logic        tb_we;
  logic [7:0]  tb_addr;
  logic [7:0]  tb_data;

  assign imem_rdata = prog[imem_addr];

  always @(posedge clk) begin
    if (tb_we) dmem[tb_addr] <= tb_data;
    else if (dmem_we) dmem[dmem_addr] <= dmem_wdata;
    if (dmem_re) dmem_rdata <= dmem[dmem_addr];
  end

  // Encoders (R1 format).
  function automatic logic [15:0] i_load(input logic [1:0] r, input logic [7:0] a);
    return {4'h1, r, 2'b00, a};
  endfunction
  function automatic logic [15:0] i_store(input logic [7:0] a);
    return {4'h2, 4'h0, a};
  endfunction
  function automatic logic [15:0] i_alu(input logic [2:0] f, input logic [1:0] x, input logic [1:0] y);
    return {4'h3, 5'b0, f, x, y};
  endfunction
  function automatic logic [15:0] i_cmp(input logic [1:0] x, input logic [1:0] y);
    return {4'h4, 8'h00, x, y};
  endfunction
  function automatic logic [15:0] i_jmp(input logic [7:0] a);
    return {4'h5, 4'h0, a};
  endfunction
  function automatic logic [15:0] i_bge(input logic [7:0] a);
    return {4'h6, 4'h0, a};
  endfunction
  localparam logic [15:0] I_HALT = 16'hF000;

  // ALU vectors: {fn, a, b, expected}
  localparam logic [26:0] ALU_VEC [8] = '{
    {3'd0, 8'hB6, 8'h5C, 8'h12},
    {3'd1, 8'hB6, 8'h5C, 8'h5A},
    {3'd2, 8'hB6, 8'h5C, 8'h14},
    {3'd3, 8'hB6, 8'h5C, 8'hFE},
    {3'd4, 8'hB6, 8'h5C, 8'hEA},
    {3'd5, 8'hB6, 8'h5C, 8'hB7},
    {3'd6, 8'hB6, 8'h5C, 8'hB5},
    {3'd7, 8'hB6, 8'h5C, 8'h6C}
  };

  // Branch vectors: {a, b, flags, final pc}
  localparam logic [26:0] BR_VEC [3] = '{
    {8'd7, 8'd3, 3'b100, 8'd7},
    {8'd5, 8'd5, 3'b010, 8'd7},
    {8'd2, 8'd9, 3'b001, 8'd5}
  };

  logic [7:0] trace [64];
  int         ntrace;
  logic [1:0] phase_log [8];
  int         nsteps;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 256; i++) prog[i] = I_HALT;
  endtask

  task automatic poke(input logic [7:0] a, input logic [7:0] d);
    tb_addr = a;
    tb_data = d;
    tb_we   = 1'b1;
    @(negedge clk);
    tb_we   = 1'b0;
  endtask

  task automatic run_prog();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n  = 1'b1;
    ntrace = 0;
    nsteps = 0;
    while (!halted_o && nsteps < 2000) begin
      if (nsteps < 8) phase_log[nsteps] = phase_o;
      if (phase_o == 2'd0 && ntrace < 64) begin
        trace[ntrace] = imem_addr;
        ntrace++;
      end
      @(negedge clk);
      nsteps++;
    end
    chk("R10 program reached halt", 32'(halted_o), 32'd1);
  endtask

  initial begin
    #(8 * 150000);
    mismatched++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [7:0] exp_tr [64];
    int         nexp;
    logic [7:0] pc_hold;

    rst_n = 1'b0;
    tb_we = 1'b0;
    tb_addr = '0;
    tb_data = '0;
    clear_prog();
    @(negedge clk);
    @(negedge clk);

    // R11 reset state
    chk("R11 pc in reset", 32'(imem_addr), 32'd0);
    chk("R11 phase in reset", 32'(phase_o), 32'd0);
    chk("R11 halted in reset", 32'(halted_o), 32'd0);
    chk("R11 acc in reset", 32'(acc_o), 32'd0);
    chk("R11 flags in reset", 32'(flags_o), 32'd0);
    chk("R11 no data access in reset", 32'({dmem_re, dmem_we}), 32'd0);

    // Counting loop: R1 R2 R3 R4 R5 R8 R9
    clear_prog();
    prog[0] = i_load(2'd1, 8'h41);
    prog[1] = i_load(2'd0, 8'h40);
    prog[2] = i_cmp(2'd0, 2'd1);
    prog[3] = i_bge(8'd7);
    prog[4] = i_alu(3'd5, 2'd0, 2'd0);
    prog[5] = i_store(8'h40);
    prog[6] = i_jmp(8'd1);
    prog[7] = I_HALT;
    poke(8'h40, 8'd0);
    poke(8'h41, 8'd4);
    run_prog();
    chk("R5 loop counter in memory", 32'(dmem[8'h40]), 32'd4);
    chk("R6 accumulator after loop", 32'(acc_o), 32'd4);
    chk("R7 flags after exit compare", 32'(flags_o), 32'b010);
    chk("R10 pc after halt at 7", 32'(imem_addr), 32'd8);
    for (int k = 0; k < 6; k++) chk("R2 phase sequence", 32'(phase_log[k]), 32'(k % 3));
    nexp = 0;
    exp_tr[nexp++] = 8'd0;
    for (int it = 0; it < 4; it++)
      for (int a = 1; a <= 6; a++) exp_tr[nexp++] = 8'(a);
    exp_tr[nexp++] = 8'd1;
    exp_tr[nexp++] = 8'd2;
    exp_tr[nexp++] = 8'd3;
    exp_tr[nexp++] = 8'd7;
    chk("R3 fetch count", 32'(ntrace), 32'(nexp));
    for (int k = 0; k < nexp; k++) chk("R3 R8 R9 fetch trace", 32'(trace[k]), 32'(exp_tr[k]));

    // R10 halt freeze
    pc_hold = imem_addr;
    repeat (6) @(negedge clk);
    chk("R10 pc frozen", 32'(imem_addr), 32'(pc_hold));
    chk("R10 still halted", 32'(halted_o), 32'd1);
    chk("R10 phase 3", 32'(phase_o), 32'd3);

    // ALU table: R4 R6 R7
    for (int v = 0; v < 8; v++) begin
      rst_n = 1'b0;
      clear_prog();
      prog[0] = i_load(2'd2, 8'h10);
      prog[1] = i_load(2'd3, 8'h11);
      prog[2] = i_alu(ALU_VEC[v][26:24], 2'd2, 2'd3);
      prog[3] = i_store(8'h20);
      poke(8'h10, ALU_VEC[v][23:16]);
      poke(8'h11, ALU_VEC[v][15:8]);
      poke(8'h20, 8'h00);
      run_prog();
      chk("R6 ALU result stored", 32'(dmem[8'h20]), 32'(ALU_VEC[v][7:0]));
      chk("R6 ALU accumulator", 32'(acc_o), 32'(ALU_VEC[v][7:0]));
      chk("R7 flags untouched by ALU", 32'(flags_o), 32'd0);
    end

    // Branch cases: R7 R9
    for (int v = 0; v < 3; v++) begin
      rst_n = 1'b0;
      clear_prog();
      prog[0] = i_load(2'd0, 8'h10);
      prog[1] = i_load(2'd1, 8'h11);
      prog[2] = i_cmp(2'd0, 2'd1);
      prog[3] = i_bge(8'd6);
      poke(8'h10, BR_VEC[v][26:19]);
      poke(8'h11, BR_VEC[v][18:11]);
      run_prog();
      chk("R7 compare flags", 32'(flags_o), 32'(BR_VEC[v][10:8]));
      chk("R9 branch outcome pc", 32'(imem_addr), 32'(BR_VEC[v][7:0]));
    end

    // Unassigned opcode: R12
    rst_n = 1'b0;
    clear_prog();
    prog[0] = i_load(2'd1, 8'h10);
    prog[1] = i_alu(3'd5, 2'd1, 2'd1);
    prog[2] = 16'h9ABC;
    prog[3] = i_store(8'h20);
    poke(8'h10, 8'h33);
    poke(8'h20, 8'h00);
    poke(8'hBC, 8'h77);
    run_prog();
    chk("R12 stored value after no-op", 32'(dmem[8'h20]), 32'h34);
    chk("R12 accumulator unchanged", 32'(acc_o), 32'h34);
    chk("R12 flags unchanged", 32'(flags_o), 32'd0);
    chk("R12 memory at field address untouched", 32'(dmem[8'hBC]), 32'h77);
    chk("R12 sequential fetch count", 32'(ntrace), 32'd5);
    chk("R12 pc after halt", 32'(imem_addr), 32'd5);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule